// File: doc/BRIEF.md
# Multichannel Conversion Sequencer with Channel-Tagged Results

This block drives the back end of a converter across a set of input channels chosen by an enable mask. It converts on one channel at a time, in ascending channel order, and wraps to the lowest enabled channel after the highest. Each time it selects a channel it pulses a reset to the filter model. It then counts a fixed number of output-rate ticks so that the filter can settle fully. On the last tick it captures the 24-bit conversion value from a stub input, records the channel that produced it, and pulses a data-ready strobe.

The captured result stays available while the next channel is already settling. An 8-bit status byte goes with every result. Its low nibble names the source channel and its top bit is an active-low "unread" flag, which clears when a result is captured and sets again when the host issues a read strobe. A mode input selects the output word. In one setting the word is the data followed by the status byte. In the other it is the data alone, right-justified with a zero top byte.

A change to the enable mask abandons the conversion in progress and starts again at the lowest enabled channel. An all-zero mask leaves the block idle.

Top module: `conv_seq`

## Requirements
- R1: After synchronous reset, drdy and filt_rst are 0, cur_ch is 0, status is 8'h80 and word_out is 0.
- R2: Results are produced for the enabled channels in ascending index order, and the order wraps from the highest enabled channel to the lowest.
- R3: filt_rst is high for the cycle after each channel selection, whether the selection follows a mask change or a captured result. It is therefore high in the same cycle as every drdy pulse.
- R4: A result is captured only on the 4th tick counted since its channel was selected. drdy is high for exactly the one cycle that follows that tick.
- R5: The status byte has bits 3:0 equal to the ID of the channel that produced the held result, bits 6:4 equal to zero, and bit 7 equal to the unread flag (0 = unread result present).
- R6: When append_stat is 1, word_out is {data[23:0], status[7:0]}. When append_stat is 0, word_out is {8'h00, data[23:0]}.
- R7: conv_data is sampled only on the capturing tick. The held data and its ID stay unchanged while the next channel settles.
- R8: With an all-zero enable mask, ticks have no effect: drdy and filt_rst stay 0.
- R9: A change of ch_en restarts the sequence at the lowest enabled channel with a fresh settling count. A tick in the same cycle as the change is not counted.
- R10: Status bit 7 goes to 0 when a result is captured and to 1 on rd. If rd and a capture fall in the same cycle, the bit stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 4 | Channel enable mask, bit n enables channel n |
| tick | input | 1 | One-cycle pulse per output-rate period |
| conv_data | input | 24 | Stub conversion value from the filter |
| append_stat | input | 1 | 1 = append status byte to data word |
| rd | input | 1 | Host read strobe, marks the held result as read |
| filt_rst | output | 1 | Filter and modulator reset pulse on channel selection |
| cur_ch | output | 2 | Channel currently being converted |
| drdy | output | 1 | One-cycle strobe when a result is captured |
| status | output | 8 | Unread flag, zero field, channel ID |
| word_out | output | 32 | Output word, layout set by append_stat |

## Verification
Two pairs of events can share a cycle. A read strobe can arrive in the same cycle as the tick that captures a new result. A mask change can arrive in the same cycle as a tick. The bench forces both collisions directly. It then expects the unread flag to stay low after the read/capture collision, and it expects the full four-tick settling interval to start over on the newly selected channel after the mask/tick collision. A table of masks then drives complete sweeps in both word layouts, comparing the ID, data and output word of every result against an order computed independently from the mask.

// File: rtl/convseq_pkg.sv
package convseq_pkg;
  localparam int ID_W   = 4;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic            rdy_n;
    logic [2:0]      rsvd;
    logic [ID_W-1:0] id;
  } status_t;
endpackage

// File: rtl/convseq_pick.sv
// Combinational channel chooser: lowest enabled and next enabled after cur.
module convseq_pick #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW-1:0]  cur,
  output logic [CW-1:0]  first_ch,
  output logic [CW-1:0]  next_ch,
  output logic           any
);
  always_comb begin
    first_ch = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (mask[k]) first_ch = CW'(k);
    end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    next_ch = cur;
    for (int k = 1; k <= NCH; k++) begin
      if (!found && mask[CW'((int'(cur) + k) % NCH)]) begin
        next_ch = CW'((int'(cur) + k) % NCH);
        found   = 1'b1;
      end
    end
  end

  assign any = |mask;

  // R2
  always_comb begin
    if (any) begin
      first_pick_chk : assert (mask[first_ch]);
      next_pick_chk  : assert (mask[next_ch]);
    end
  end
endmodule

// File: rtl/convseq_settle.sv
// Settling-period counter; done fires on the last counted tick.
module convseq_settle #(
  parameter int SETTLE = 4,
  parameter int SW     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic done
);
  localparam logic [SW-1:0] LAST = SW'(SETTLE - 1);

  logic [SW-1:0] cnt_q;

  assign done = adv && !clr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (adv)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // R4
  cnt_range_chk : assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R4
  done_wrap_chk : assert property (@(posedge clk) disable iff (rst)
    done |=> (cnt_q == '0));
endmodule

// File: rtl/convseq_hold.sv
// Result holding register with unread flag and capture strobe.
module convseq_hold #(
  parameter int DATA_W = 24,
  parameter int CW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lat,
  input  logic              rd,
  input  logic [DATA_W-1:0] din,
  input  logic [CW-1:0]     id_in,
  output logic [DATA_W-1:0] dout,
  output logic [CW-1:0]     id,
  output logic              rdy_n,
  output logic              drdy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      id    <= '0;
      rdy_n <= 1'b1;
      drdy  <= 1'b0;
    end else begin
      drdy <= lat;
      if (lat) begin
        dout  <= din;
        id    <= id_in;
        rdy_n <= 1'b0;
      end else if (rd) begin
        rdy_n <= 1'b1;
      end
    end
  end

  // R10
  lat_clears_chk : assert property (@(posedge clk) disable iff (rst)
    lat |=> !rdy_n);
  // R10
  rd_sets_chk : assert property (@(posedge clk) disable iff (rst)
    (rd && !lat) |=> rdy_n);
  // R7
  hold_stable_chk : assert property (@(posedge clk) disable iff (rst)
    !lat |=> ($stable(dout) && $stable(id)));
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int NCH    = 4,
  parameter int DATA_W = 24,
  parameter int SETTLE = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        ch_en,
  input  logic                  tick,
  input  logic [DATA_W-1:0]     conv_data,
  input  logic                  append_stat,
  input  logic                  rd,
  output logic                  filt_rst,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] cur_ch,
  output logic                  drdy,
  output logic [7:0]            status,
  output logic [DATA_W+7:0]     word_out
);
  import convseq_pkg::*;

  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SW    = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam int OUT_W = DATA_W + STAT_W;

  logic [NCH-1:0]    en_q;
  logic              active_q;
  logic [CW-1:0]     cur_q;
  logic              frst_q;
  logic              restart, adv, done, any;
  logic [CW-1:0]     first_ch, next_ch, id_q;
  logic [DATA_W-1:0] data_q;
  logic              rdy_n_q, drdy_q;
  status_t           st;

  assign restart = (ch_en != en_q);
  assign adv     = active_q && tick && !restart;

  convseq_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .mask     (ch_en),
    .cur      (cur_q),
    .first_ch (first_ch),
    .next_ch  (next_ch),
    .any      (any)
  );

  convseq_settle #(.SETTLE(SETTLE), .SW(SW)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .clr  (restart),
    .adv  (adv),
    .done (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      active_q <= 1'b0;
      cur_q    <= '0;
      frst_q   <= 1'b0;
    end else begin
      en_q   <= ch_en;
      frst_q <= 1'b0;
      if (restart) begin
        active_q <= any;
        cur_q    <= first_ch;
        frst_q   <= any;
      end else if (done) begin
        cur_q  <= next_ch;
        frst_q <= 1'b1;
      end
    end
  end

  convseq_hold #(.DATA_W(DATA_W), .CW(CW)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .lat   (done),
    .rd    (rd),
    .din   (conv_data),
    .id_in (cur_q),
    .dout  (data_q),
    .id    (id_q),
    .rdy_n (rdy_n_q),
    .drdy  (drdy_q)
  );

  always_comb begin
    st.rdy_n = rdy_n_q;
    st.rsvd  = '0;
    st.id    = ID_W'(id_q);
  end

  assign filt_rst = frst_q;
  assign cur_ch   = cur_q;
  assign drdy     = drdy_q;
  assign status   = st;
  assign word_out = append_stat ? OUT_W'({data_q, st}) : OUT_W'(data_q);

  // R3
  rst_with_drdy_chk : assert property (@(posedge clk) disable iff (rst)
    drdy |-> filt_rst);
  // R4
  drdy_after_tick_chk : assert property (@(posedge clk) disable iff (rst)
    drdy |-> $past(tick));
  // R8
  idle_no_drdy_chk : assert property (@(posedge clk) disable iff (rst)
    (ch_en == '0) |=> !drdy);
  // R9
  restart_no_drdy_chk : assert property (@(posedge clk) disable iff (rst)
    restart |=> !drdy);
endmodule

// File: tb/sim_conv_seq.sv
module sim_conv_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ch_en = '0;
  logic        tick = 1'b0;
  logic [23:0] conv_data = '0;
  logic        append_stat = 1'b0;
  logic        rd = 1'b0;
  logic        filt_rst, drdy;
  logic [1:0]  cur_ch;
  logic [7:0]  status;
  logic [31:0] word_out;

  int checks = 0;
  int errors = 0;
  logic seen_drdy, seen_frst;

  always #10 clk = ~clk;

  conv_seq u0 (
    .clk(clk), .rst(rst), .ch_en(ch_en), .tick(tick), .conv_data(conv_data),
    .append_stat(append_stat), .rd(rd), .filt_rst(filt_rst), .cur_ch(cur_ch),
    .drdy(drdy), .status(status), .word_out(word_out)
  );

  localparam logic [3:0] MASKS [6] = '{4'b1111, 4'b0101, 4'b1000,
                                       4'b0110, 4'b1001, 4'b1011};
  localparam logic       APPS  [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic r);
    @(negedge clk);
    tick = t;
    rd   = r;
    @(negedge clk);
    tick = 1'b0;
    rd   = 1'b0;
    seen_drdy |= drdy;
    seen_frst |= filt_rst;
  endtask

  task automatic setm(input logic [3:0] m, input logic t);
    @(negedge clk);
    ch_en = m;
    tick  = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic [1:0] lowest(input logic [3:0] m);
    logic [1:0] r;
    r = 2'd0;
    for (int k = 3; k >= 0; k--) if (m[k]) r = 2'(k);
    return r;
  endfunction

  function automatic logic [1:0] after(input logic [3:0] m, input logic [1:0] c);
    for (int k = 1; k <= 4; k++) if (m[(int'(c) + k) % 4]) return 2'((int'(c) + k) % 4);
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0]  ec;
    logic [7:0]  est;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 drdy", 32'(drdy), 0);
    chk("R1 filt_rst", 32'(filt_rst), 0);
    chk("R1 cur_ch", 32'(cur_ch), 0);
    chk("R1 status", 32'(status), 32'h80);
    chk("R1 word_out", word_out, 0);

    // R8 idle with zero mask
    seen_drdy = 0; seen_frst = 0;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    chk("R8 no drdy", 32'(seen_drdy), 0);
    chk("R8 no filt_rst", 32'(seen_frst), 0);

    // table walk: R2 R3 R4 R5 R6 R9 R10
    for (int i = 0; i < 6; i++) begin
      append_stat = APPS[i];
      setm(MASKS[i], 1'b0);
      ec = lowest(MASKS[i]);
      chk("R9 restart channel", 32'(cur_ch), 32'(ec));
      chk("R3 filt_rst on select", 32'(filt_rst), 1);
      for (int c = 0; c < $countones(MASKS[i]) + 1; c++) begin
        conv_data = {8'(i), 8'(c), 8'hA5};
        seen_drdy = 0;
        for (int t = 0; t < 3; t++) step(1'b1, 1'b0);
        chk("R4 early drdy", 32'(seen_drdy), 0);
        step(1'b1, 1'b0);
        est = {1'b0, 3'b000, 2'b00, ec};
        chk("R4 drdy", 32'(drdy), 1);
        chk("R3 filt_rst with result", 32'(filt_rst), 1);
        chk("R5 status", 32'(status), 32'(est));
        chk("R6 word", word_out, APPS[i] ? {conv_data, est} : {8'h00, conv_data});
        ec = after(MASKS[i], ec);
        chk("R2 next channel", 32'(cur_ch), 32'(ec));
        step(1'b0, 1'b1);
        chk("R10 read sets flag", 32'(status[7]), 1);
      end
    end

    // R7 held result stable while next channel settles
    append_stat = 1'b1;
    setm(4'b0011, 1'b0);
    conv_data = 24'h123456;
    for (int t = 0; t < 4; t++) step(1'b1, 1'b0);
    held = word_out;
    chk("R7 captured", held, {24'h123456, 8'h00});
    conv_data = 24'hFEDCBA;
    for (int t = 0; t < 3; t++) step(1'b1, 1'b0);
    chk("R7 held stable", word_out, held);

    // R10 collision: read in the capturing cycle keeps flag low
    step(1'b1, 1'b1);
    chk("R10 collision drdy", 32'(drdy), 1);
    chk("R10 collision flag", 32'(status), 32'h01);
    step(1'b0, 1'b1);
    chk("R10 read after", 32'(status), 32'h81);

    // R9 mask change with tick in same cycle restarts count
    setm(4'b1111, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    setm(4'b1100, 1'b1);
    chk("R9 restart lowest", 32'(cur_ch), 2);
    chk("R9 no drdy on restart", 32'(drdy), 0);
    seen_drdy = 0;
    for (int t = 0; t < 3; t++) step(1'b1, 1'b0);
    chk("R9 fresh count", 32'(seen_drdy), 0);
    step(1'b1, 1'b0);
    chk("R9 result after 4", 32'(drdy), 1);
    chk("R5 id after restart", 32'(status[3:0]), 2);

    // R8 mask back to zero stops results
    setm(4'b0000, 1'b0);
    seen_drdy = 0; seen_frst = 0;
    for (int t = 0; t < 8; t++) step(1'b1, 1'b0);
    chk("R8 idle again drdy", 32'(seen_drdy), 0);
    chk("R8 idle again filt_rst", 32'(seen_frst), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule